// File: doc/BRIEF.md
# Per-Source Interrupt Routing Controller

This block steers 112 level-sensitive peripheral interrupt lines to two processor cores. Every source owns one 16-bit routing register. The two low bits of that register form a destination bitmap, one bit per core. A source can therefore reach core 0 only, core 1 only, both cores, or neither.

Software programs the bitmaps through a small single-cycle register bus that does halfword reads and writes. The routing window covers byte offsets 0x880 to 0x95F, one halfword per source. The block drives one 112-bit interrupt vector per core. Each bit is the live input level gated by the stored enable for that core, so level semantics pass through unchanged. After reset every enable is clear and nothing reaches either core.

Top module: `irq_route_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, every routing enable is zero. Both core outputs stay zero whatever `irq_in` holds, and every routing register reads back 0.
- R2: A write with `bus_sel`=1 and `bus_we`=1 to byte address 0x880 + 2*n (n in 0..111) stores `bus_wdata[0]` as the core-0 enable of source n and `bus_wdata[1]` as the core-1 enable of source n.
- R3: `core0_irq[n]` equals `irq_in[n]` AND the core-0 enable of source n. This path is combinational, with no latching.
- R4: `core1_irq[n]` equals `irq_in[n]` AND the core-1 enable of source n. This path is combinational, with no latching.
- R5: A read (`bus_sel`=1, `bus_we`=0) of source n's register returns, on `bus_rdata` in the following cycle, the core-0 enable in bit 0 and the core-1 enable in bit 1, with bits 15:2 zero.
- R6: Bits 15:2 of a routing write are discarded, so a later read of that register shows them as zero.
- R7: A write to an address below 0x880 or at or above 0x960 changes no enable.
- R8: A read of an address outside 0x880..0x95F returns 0 in the following cycle.
- R9: A write to one source's register leaves the enables of all other sources unchanged.
- R10: A new enable takes effect in the cycle after the write. During the write cycle itself, the outputs still use the old enable.
- R11: In any cycle that does not follow a read request, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the halfword |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| irq_in | input | 112 | Level interrupt inputs, one per source |
| core0_irq | output | 112 | Gated interrupt vector for core 0 |
| core1_irq | output | 112 | Gated interrupt vector for core 1 |

## Verification
A routing write and live gating of the same source can fall in the same cycle. The bench holds the source's input high, programs that source to disabled, and then issues a write that enables both cores. It samples both output bits while the write is still presented, where they must stay low because the old enable applies. It samples them again after the clock edge, where both must be high. A full-vector compare at that point also shows that no other source moved.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_SRC   = 112;
    localparam int NUM_CORE  = 2;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam int WIN_BASE  = 'h880;
    localparam int WIN_BYTES = 2 * NUM_SRC;
    localparam int WIN_END   = WIN_BASE + WIN_BYTES;
    localparam int IDX_W     = $clog2(NUM_SRC);

    typedef logic [NUM_SRC-1:0]  src_vec_t;
    typedef logic [NUM_CORE-1:0] core_map_t;
    typedef logic [IDX_W-1:0]    src_idx_t;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic     hit;
        src_idx_t idx;
    } win_dec_t;

    function automatic logic [DATA_W-1:0] pack_map(input core_map_t m);
        return DATA_W'(m);
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_BASE   = WIN_BASE,
    parameter int P_END    = WIN_END,
    parameter int P_IDX_W  = IDX_W
) (
    input  logic [P_ADDR_W-1:0] addr,
    output logic                hit,
    output logic [P_IDX_W-1:0]  idx
);
    localparam logic [P_ADDR_W-1:0] BASE_A = P_ADDR_W'(P_BASE);
    localparam logic [P_ADDR_W-1:0] END_A  = P_ADDR_W'(P_END);

    logic [P_ADDR_W-1:0] off;
    logic                unused_off_bits;

    assign off = addr - BASE_A;
    assign hit = (addr >= BASE_A) && (addr < END_A);
    assign idx = off[P_IDX_W:1];
    assign unused_off_bits = ^{off[P_ADDR_W-1:P_IDX_W+1], off[0]};

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int P_SRC   = NUM_SRC,
    parameter int P_CORE  = NUM_CORE,
    parameter int P_IDX_W = IDX_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic [P_IDX_W-1:0]             idx,
    input  logic [P_CORE-1:0]              wmap,
    output logic [P_CORE-1:0][P_SRC-1:0]   en,
    output logic [P_CORE-1:0]              rmap
);
    logic [P_SRC-1:0] row_sel;

    for (genvar s = 0; s < P_SRC; s++) begin : g_sel
        assign row_sel[s] = (idx == P_IDX_W'(s));
    end

    for (genvar c = 0; c < P_CORE; c++) begin : g_core
        logic [P_SRC-1:0] en_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q <= '0;
            end else if (wr) begin
                for (int s = 0; s < P_SRC; s++) begin
                    if (row_sel[s]) en_q[s] <= wmap[c];
                end
            end
        end

        assign en[c]   = en_q;
        assign rmap[c] = |(en_q & row_sel);
    end

endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate
    import irq_route_pkg::*;
#(
    parameter int P_SRC  = NUM_SRC,
    parameter int P_CORE = NUM_CORE
) (
    input  logic [P_SRC-1:0]             lvl,
    input  logic [P_CORE-1:0][P_SRC-1:0] en,
    output logic [P_CORE-1:0][P_SRC-1:0] out
);
    for (genvar c = 0; c < P_CORE; c++) begin : g_core
        assign out[c] = lvl & en[c];
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [111:0]      irq_in,
    output logic [111:0]      core0_irq,
    output logic [111:0]      core1_irq
);
    bus_req_t                           req;
    win_dec_t                           dec;
    core_map_t                          rmap;
    logic [NUM_CORE-1:0][NUM_SRC-1:0]   en;
    logic [NUM_CORE-1:0][NUM_SRC-1:0]   gated;
    logic [DATA_W-1:0]                  rdata_q;
    logic                               unused_wdata_hi;

    assign req = '{sel: bus_sel, we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign unused_wdata_hi = ^req.wdata[DATA_W-1:NUM_CORE];

    irq_route_decode u_dec (
        .addr (req.addr),
        .hit  (dec.hit),
        .idx  (dec.idx)
    );

    irq_route_table u_tbl (
        .clk  (clk),
        .rst  (rst),
        .wr   (req.sel && req.we && dec.hit),
        .idx  (dec.idx),
        .wmap (req.wdata[NUM_CORE-1:0]),
        .en   (en),
        .rmap (rmap)
    );

    irq_route_gate u_gate (
        .lvl (irq_in),
        .en  (en),
        .out (gated)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.sel && !req.we && dec.hit) begin
            rdata_q <= pack_map(rmap);
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign core0_irq = gated[0];
    assign core1_irq = gated[1];

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         bus_sel,
    input logic         bus_we,
    input logic [11:0]  bus_addr,
    input logic [15:0]  bus_wdata,
    input logic [15:0]  bus_rdata,
    input logic [111:0] irq_in,
    input logic [111:0] core0_irq,
    input logic [111:0] core1_irq
);
    logic out_of_win;
    logic unused_chk;

    assign out_of_win = (bus_addr < 12'(WIN_BASE)) || (bus_addr >= 12'(WIN_END));
    assign unused_chk = ^bus_wdata;

    // R1: first cycle after reset, nothing routed
    a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (core0_irq == '0) && (core1_irq == '0));

    // R3: core 0 output never asserts without its input
    a_r3_core0_subset: assert property (@(posedge clk) disable iff (rst)
        (core0_irq & ~irq_in) == '0);

    // R4: core 1 output never asserts without its input
    a_r4_core1_subset: assert property (@(posedge clk) disable iff (rst)
        (core1_irq & ~irq_in) == '0);

    // R5: upper read bits are zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[15:2] == '0);

    // R7: write outside the window leaves routing untouched
    a_r7_miss_write: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_sel && bus_we && out_of_win) && $stable(irq_in))
        |-> ($stable(core0_irq) && $stable(core1_irq)));

    // R10: with no write and steady inputs, outputs hold
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!(bus_sel && bus_we)) && $stable(irq_in))
        |-> ($stable(core0_irq) && $stable(core1_irq)));

    // R11: no read request, no read data
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_sel && !bus_we) |-> bus_rdata == '0);

endmodule

bind irq_route_ctrl irq_route_ctrl_chk u_chk (.*);

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 112;
    localparam logic [11:0] BASE = 12'h880;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [NS-1:0] irq_in = '0;
    logic [NS-1:0] core0_irq;
    logic [NS-1:0] core1_irq;

    irq_route_ctrl u_irq_route_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [NS-1:0] m_en0 = '0;
    logic [NS-1:0] m_en1 = '0;

    typedef struct { logic [15:0] exp; string tag; } rd_item_t;
    rd_item_t rd_q[$];
    logic rd_pend = 1'b0;

    task automatic chk(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: registered read data is judged one cycle after the request
    always @(posedge clk) rd_pend <= bus_sel && !bus_we && !rst;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (rd_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R5 act=%h exp=<none queued>", bus_rdata);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                chk(it.tag, NS'(bus_rdata), NS'(it.exp));
            end
        end else if (!rst) begin
            chk("R11", NS'(bus_rdata), '0);
        end
    end

    function automatic bit in_win(logic [11:0] a);
        return (a >= BASE) && (a < BASE + 12'(2*NS));
    endfunction

    task automatic wr(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        if (in_win(a)) begin
            m_en0[(a - BASE) >> 1] = d[0];
            m_en1[(a - BASE) >> 1] = d[1];
        end
    endtask

    task automatic rd(logic [11:0] a, string tag);
        rd_item_t it;
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        it.tag = tag;
        it.exp = in_win(a) ? {14'b0, m_en1[(a - BASE) >> 1], m_en0[(a - BASE) >> 1]} : 16'h0;
        rd_q.push_back(it);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic drive_and_check(logic [NS-1:0] v, string tag0, string tag1);
        @(negedge clk);
        irq_in = v;
        #1;
        chk(tag0, core0_irq, v & m_en0);
        chk(tag1, core1_irq, v & m_en1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_en0 = '0; m_en1 = '0;
    endtask

    initial begin
        logic [NS-1:0] alt;
        alt = {(NS/2){2'b01}};
        do_reset();
        // R1: nothing routed after reset
        drive_and_check('1, "R1 core0", "R1 core1");
        rd(BASE, "R1 read src0");
        rd(BASE + 12'd222, "R1 read src111");

        // R2 R3 R4 R5 R6: every source through all four destination patterns
        for (int r = 0; r < 4; r++) begin
            for (int n = 0; n < NS; n++) begin
                logic [1:0] p;
                p = 2'((n + r) % 4);
                wr(BASE + 12'(2*n), {14'h3FFF, p});
            end
            for (int n = 0; n < NS; n++) rd(BASE + 12'(2*n), "R5 R6 readback");
            drive_and_check('1, "R2 R3 all-high", "R2 R4 all-high");
            drive_and_check(alt, "R3 alternating", "R4 alternating");
            drive_and_check(~alt, "R3 inverse", "R4 inverse");
        end

        // R7 R8: accesses outside the window
        wr(12'h87E, 16'h0003);
        wr(12'h960, 16'h0000);
        wr(12'h000, 16'h0003);
        wr(12'hFFE, 16'h0000);
        drive_and_check('1, "R7 core0", "R7 core1");
        rd(12'h87E, "R8 below");
        rd(12'h960, "R8 above");
        rd(12'hFFE, "R8 top");

        // R9 R10: write and live gating in the same cycle
        wr(BASE + 12'd10, 16'h0000);
        @(negedge clk);
        irq_in = '1;
        bus_sel = 1; bus_we = 1; bus_addr = BASE + 12'd10; bus_wdata = 16'h0003;
        #1;
        chk("R10 old core0", NS'(core0_irq[5]), '0);
        chk("R10 old core1", NS'(core1_irq[5]), '0);
        @(posedge clk);
        #1;
        m_en0[5] = 1; m_en1[5] = 1;
        chk("R10 R9 core0", core0_irq, irq_in & m_en0);
        chk("R10 R9 core1", core1_irq, irq_in & m_en1);
        @(negedge clk);
        bus_sel = 0; bus_we = 0;

        // R1: reset after programming clears everything
        do_reset();
        drive_and_check('1, "R1 re-reset core0", "R1 re-reset core1");
        rd(BASE + 12'd10, "R1 re-reset read");
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule